// File: doc/BRIEF.md
# UART FIFO and interrupt identification

This block sits between the serial shifters of a UART and the host register bus. Received characters arrive from a deserializer as single-cycle pulses and are queued in a receive FIFO. Characters that the host writes are queued in a transmit FIFO and handed to a serializer through a valid/ready handshake. A byte-wide register port gives access to the data queues, a three-bit interrupt mask, a control register (write) that shares an offset with the identification register (read), and a line status byte.

One registered interrupt output tells the host that at least one enabled cause is pending. The host reads the identification byte to find out which cause has the highest priority. A line error outranks receive data, and receive data outranks transmit-empty. Each cause clears on the register access that services it. The receive-data cause follows a programmable fill threshold. With the FIFOs switched off, both directions fall back to a single holding character.

Register offsets on `reg_addr`: 0 = data (read pops receive, write pushes transmit), 1 = interrupt mask, 2 = identification (read) / control (write), 3 = line status (read only).

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset `irq` and `tx_valid` are 0, the mask reads back 0x00, the identification byte reads 0x01 and the FIFOs are disabled.
- R2: Control bit 0 turns on 16-deep receive and transmit FIFOs. While it is 0 each direction holds one character. Any write that changes bit 0 empties both FIFOs.
- R3: A control write with bit 1 set empties the receive FIFO and one with bit 2 set empties the transmit FIFO. Neither bit is retained, so a later control write without them leaves the queues intact.
- R4: Control bits 7:6 choose the receive threshold (0→1, 1→4, 2→8, 3→14 characters; 1 when FIFOs are off). The receive-data cause is active exactly while the fill level is at or above the threshold.
- R5: Mask bit 0 enables the receive-data cause, bit 1 transmit-empty and bit 2 line error. A masked cause neither raises `irq` nor appears in the identification byte, and the mask reads back in bits 2:0 of offset 1.
- R6: Identification byte: bit 0 is 1 when nothing is pending and 0 otherwise. Bits 3:1 hold the cause code. Bits 7:6 both equal the FIFO enable bit. Bits 5:4 are 0.
- R7: Cause codes by priority: 3 = line error, then 2 = receive data, then 1 = transmit empty. Only the highest pending one is reported.
- R8: A character that arrives while the receive FIFO is full is dropped and sets the overrun flag (line status bit 1). The flag stays set until line status is read.
- R9: The transmit-empty flag sets when the serializer takes the last queued character, or when mask bit 1 goes from 0 to 1 with the transmit FIFO empty. It clears on a data write, or on an identification read that returns code 1.
- R10: `irq` is registered: in each cycle it equals whether any enabled cause was pending in the previous cycle.
- R11: Data writes queue characters that appear in order on `tx_char` while `tx_valid` is 1. Each character leaves when `tx_ready` is 1. A write to a full transmit FIFO is dropped.
- R12: A data read returns the oldest received character and removes it. A read of an empty FIFO returns 0x00. Line status bit 0 is 1 while receive data is present and bit 5 is 1 while the transmit FIFO is empty.
- R13: `reg_rdata` is registered. It takes the addressed value in the cycle after a read strobe and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received character strobe from the deserializer |
| rx_char | input | CHAR_W | Received character |
| tx_valid | output | 1 | Transmit character available |
| tx_char | output | CHAR_W | Oldest transmit character |
| tx_ready | input | 1 | Serializer takes the character |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that reset is held for at least one edge and that every input is known from the first edge onward. They also assume that a receive strobe in the same cycle as a receive flush is simply discarded and never counted as an overrun. The stimulus drives every input from time zero on the falling edge. It never issues a read and a write in the same cycle, and it keeps `rx_valid` to single-cycle pulses, so the overrun, flush and threshold properties only see the orderings the requirements describe.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_TX_EMPTY = 3'd1,
    CAUSE_RX_AVAIL = 3'd2,
    CAUSE_LINE     = 3'd3
  } cause_e;

  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_MASK  = 2'd1,
    REG_CAUSE = 2'd2,
    REG_LINE  = 2'd3
  } reg_addr_e;

  function automatic int unsigned trig_chars(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_char_fifo.sv
module uart_char_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          push_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_go, push_go;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_go  = pop && (count != '0);
  assign push_ok = (count < lim) || pop_go;
  assign push_go = push && push_ok;

  always_ff @(posedge clk) begin
    if (push_go && !clr) mem[wr_ptr] <= din;
  end

  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_go) wr_ptr <= step(wr_ptr);
      if (pop_go)  rd_ptr <= step(rd_ptr);
      case ({push_go, pop_go})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/uart_cause_encoder.sv
module uart_cause_encoder
  import uart_fifo_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [2:0]    mask,
  input  logic          line_err,
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] rx_trigger,
  input  logic          tx_empty_flag,
  input  logic          fifo_on,
  output cause_e        cause,
  output logic          pending,
  output logic [7:0]    cause_byte
);

  logic src_line, src_rx, src_tx;

  always_comb begin
    src_line = mask[2] & line_err;
    src_rx   = mask[0] & (rx_level >= rx_trigger);
    src_tx   = mask[1] & tx_empty_flag;
    if (src_line)    cause = CAUSE_LINE;
    else if (src_rx) cause = CAUSE_RX_AVAIL;
    else if (src_tx) cause = CAUSE_TX_EMPTY;
    else             cause = CAUSE_NONE;
    pending    = src_line | src_rx | src_tx;
    cause_byte = {fifo_on, fifo_on, 2'b00, cause, ~pending};
  end

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16,
  parameter int CHAR_W   = 8,
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_char,
  input  logic              tx_ready,
  output logic              irq
);

  logic             fifo_on;
  logic [1:0]       trig_sel;
  logic [2:0]       mask;
  logic             line_err;
  logic             thr_flag;

  logic wr_data_s, wr_mask_s, wr_ctrl_s;
  logic rd_data_s, rd_cause_s, rd_line_s;
  logic mode_flip, rx_flush, tx_flush;

  logic [RX_CW-1:0]  rx_count, rx_lim, rx_trig;
  logic [TX_CW-1:0]  tx_count, tx_lim;
  logic [CHAR_W-1:0] rx_head;
  logic              rx_push_ok, tx_push_ok, tx_pop, rx_overrun_ev;

  cause_e     cause;
  logic       pending;
  logic [7:0] cause_byte;
  logic [7:0] rd_mux;

  assign wr_data_s  = reg_wr && (reg_addr == REG_DATA);
  assign wr_mask_s  = reg_wr && (reg_addr == REG_MASK);
  assign wr_ctrl_s  = reg_wr && (reg_addr == REG_CAUSE);
  assign rd_data_s  = reg_rd && (reg_addr == REG_DATA);
  assign rd_cause_s = reg_rd && (reg_addr == REG_CAUSE);
  assign rd_line_s  = reg_rd && (reg_addr == REG_LINE);

  assign mode_flip = wr_ctrl_s && (reg_wdata[0] != fifo_on);
  assign rx_flush  = wr_ctrl_s && (reg_wdata[1] || mode_flip);
  assign tx_flush  = wr_ctrl_s && (reg_wdata[2] || mode_flip);

  assign rx_lim  = fifo_on ? RX_CW'(RX_DEPTH) : RX_CW'(1);
  assign tx_lim  = fifo_on ? TX_CW'(TX_DEPTH) : TX_CW'(1);
  assign rx_trig = fifo_on ? RX_CW'(trig_chars(trig_sel)) : RX_CW'(1);

  uart_char_fifo #(.W(CHAR_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr     (rx_flush),
    .lim     (rx_lim),
    .push    (rx_valid),
    .pop     (rd_data_s),
    .din     (rx_char),
    .dout    (rx_head),
    .count   (rx_count),
    .push_ok (rx_push_ok)
  );

  assign tx_valid = (tx_count != '0);
  assign tx_pop   = tx_valid && tx_ready;

  uart_char_fifo #(.W(CHAR_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr     (tx_flush),
    .lim     (tx_lim),
    .push    (wr_data_s),
    .pop     (tx_pop),
    .din     (reg_wdata[CHAR_W-1:0]),
    .dout    (tx_char),
    .count   (tx_count),
    .push_ok (tx_push_ok)
  );

  assign rx_overrun_ev = rx_valid && !rx_push_ok && !rx_flush;

  uart_cause_encoder #(.CW(RX_CW)) u_cause (
    .mask          (mask),
    .line_err      (line_err),
    .rx_level      (rx_count),
    .rx_trigger    (rx_trig),
    .tx_empty_flag (thr_flag),
    .fifo_on       (fifo_on),
    .cause         (cause),
    .pending       (pending),
    .cause_byte    (cause_byte)
  );

  always_comb begin
    case (reg_addr_e'(reg_addr))
      REG_DATA:  rd_mux = (rx_count != '0) ? 8'(rx_head) : 8'h00;
      REG_MASK:  rd_mux = {5'b00000, mask};
      REG_CAUSE: rd_mux = cause_byte;
      default:   rd_mux = {2'b00, (tx_count == '0), 3'b000, line_err, (rx_count != '0)};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_on   <= 1'b0;
      trig_sel  <= 2'd0;
      mask      <= 3'd0;
      line_err  <= 1'b0;
      thr_flag  <= 1'b0;
      reg_rdata <= 8'h00;
      irq       <= 1'b0;
    end else begin
      irq <= pending;
      if (wr_ctrl_s) begin
        fifo_on  <= reg_wdata[0];
        trig_sel <= reg_wdata[7:6];
      end
      if (wr_mask_s) mask <= reg_wdata[2:0];
      if (rx_overrun_ev)  line_err <= 1'b1;
      else if (rd_line_s) line_err <= 1'b0;
      if (wr_data_s)
        thr_flag <= 1'b0;
      else if (rd_cause_s && (cause == CAUSE_TX_EMPTY))
        thr_flag <= 1'b0;
      else if (tx_pop && (tx_count == TX_CW'(1)))
        thr_flag <= 1'b1;
      else if (wr_mask_s && reg_wdata[1] && !mask[1] && (tx_count == '0))
        thr_flag <= 1'b1;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int RX_CW    = 5,
  parameter int TX_CW    = 5,
  parameter int TX_DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             pending,
  input logic [RX_CW-1:0] rx_count,
  input logic [RX_CW-1:0] rx_lim,
  input logic [TX_CW-1:0] tx_count,
  input logic             thr_flag,
  input logic             line_err,
  input logic             rd_line_s,
  input logic             rx_flush
);

  // R2: receive fill never passes the active depth
  p_rx_bound_r2: assert property (@(posedge clk) disable iff (rst)
    rx_count <= rx_lim);

  // R11: transmit fill never passes the configured depth
  p_tx_bound_r11: assert property (@(posedge clk) disable iff (rst)
    tx_count <= TX_CW'(TX_DEPTH));

  // R9: transmit-empty flag only while the transmit queue is empty
  p_thre_empty_r9: assert property (@(posedge clk) disable iff (rst)
    thr_flag |-> (tx_count == '0));

  // R8: overrun stays until line status is read
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(line_err) && !$past(rd_line_s)) |-> line_err);

  // R3: a receive flush leaves the queue empty
  p_rx_flush_r3: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (rx_count == '0));

  // R10: the request only rises after a pending cause
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(pending));

endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(
  .RX_CW(RX_CW), .TX_CW(TX_CW), .TX_DEPTH(TX_DEPTH)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .pending   (pending),
  .rx_count  (rx_count),
  .rx_lim    (rx_lim),
  .tx_count  (tx_count),
  .thr_flag  (thr_flag),
  .line_err  (line_err),
  .rd_line_s (rd_line_s),
  .rx_flush  (rx_flush)
);

// File: tb/uart_fifo_irq_bench.sv
module uart_fifo_irq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic       tx_valid;
  logic [7:0] tx_char;
  logic       tx_ready = 1'b0;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_fifo_irq u_uart_fifo_irq (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_char(rx_char),
    .tx_valid(tx_valid), .tx_char(tx_char), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_rx[$];
  logic [7:0] m_tx[$];
  bit         m_fen, m_ovr, m_thr, m_irq;
  bit   [1:0] m_trig;
  bit   [2:0] m_mask;
  logic [7:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_rx.delete(); m_tx.delete();
      m_fen = 0; m_ovr = 0; m_thr = 0; m_irq = 0; m_trig = 0; m_mask = 0; m_rdata = 8'h00;
    end else begin
      int lvl, dep, code, rxn, txn;
      bit ls, ra, te, rdpop, txpop, ok, flip, ovr_set;
      logic [7:0] idb;
      rxn = m_rx.size(); txn = m_tx.size();
      lvl = !m_fen ? 1 : (m_trig == 0 ? 1 : m_trig == 1 ? 4 : m_trig == 2 ? 8 : 14);
      ls = m_mask[2] && m_ovr;
      ra = m_mask[0] && (rxn >= lvl);
      te = m_mask[1] && m_thr;
      code = ls ? 3 : ra ? 2 : te ? 1 : 0;
      idb = {m_fen, m_fen, 2'b00, 3'(code), (code == 0)};
      if (reg_rd) begin
        case (reg_addr)
          2'd0:    m_rdata = (rxn > 0) ? m_rx[0] : 8'h00;
          2'd1:    m_rdata = {5'b00000, m_mask};
          2'd2:    m_rdata = idb;
          default: m_rdata = {2'b00, (txn == 0), 3'b000, m_ovr, (rxn != 0)};
        endcase
      end
      dep   = m_fen ? 16 : 1;
      flip  = reg_wr && reg_addr == 2 && (reg_wdata[0] != m_fen);
      rdpop = reg_rd && reg_addr == 0 && rxn > 0;
      txpop = txn > 0 && tx_ready;
      ovr_set = 0;
      if (reg_wr && reg_addr == 2 && (reg_wdata[1] || flip)) m_rx.delete();
      else begin
        ok = (rxn < dep) || rdpop;
        if (rdpop) void'(m_rx.pop_front());
        if (rx_valid) begin
          if (ok) m_rx.push_back(rx_char);
          else ovr_set = 1;
        end
      end
      if (reg_wr && reg_addr == 2 && (reg_wdata[2] || flip)) m_tx.delete();
      else begin
        ok = (txn < dep) || txpop;
        if (txpop) void'(m_tx.pop_front());
        if (reg_wr && reg_addr == 0 && ok) m_tx.push_back(reg_wdata);
      end
      if (ovr_set) m_ovr = 1;
      else if (reg_rd && reg_addr == 3) m_ovr = 0;
      if (reg_wr && reg_addr == 0) m_thr = 0;
      else if (reg_rd && reg_addr == 2 && code == 1) m_thr = 0;
      else if (txpop && txn == 1) m_thr = 1;
      else if (reg_wr && reg_addr == 1 && reg_wdata[1] && !m_mask[1] && txn == 0) m_thr = 1;
      if (reg_wr && reg_addr == 1) m_mask = reg_wdata[2:0];
      if (reg_wr && reg_addr == 2) begin
        m_fen = reg_wdata[0];
        m_trig = reg_wdata[7:6];
      end
      m_irq = (code != 0);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check8("R10 irq vs model", {7'd0, irq}, {7'd0, m_irq});
      check8("R13 rdata vs model", reg_rdata, m_rdata);
      check8("R11 tx_valid vs model", {7'd0, tx_valid}, {7'd0, m_tx.size() != 0});
      if (m_tx.size() != 0) check8("R11 tx_char vs model", tx_char, m_tx[0]);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic push(input logic [7:0] c);
    rx_char = c; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int pops;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check8("R1 irq after reset", {7'd0, irq}, 8'h00);
    check8("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
    rd(2'd2, v); check8("R1 ident after reset", v, 8'h01);
    rd(2'd1, v); check8("R1 mask after reset", v, 8'h00);

    // R5 mask, R9 enable-rising sets transmit-empty, R10 irq
    wr(2'd1, 8'h07);
    tick(); check8("R10 irq after cause", {7'd0, irq}, 8'h01);
    rd(2'd1, v); check8("R5 mask readback", v, 8'h07);

    // FIFO off: single holding char, overrun and priority
    push(8'hA1); push(8'hA2);
    rd(2'd2, v); check8("R7 line error first", v, 8'h06);
    rd(2'd3, v); check8("R8 overrun in line status", v, 8'h23);
    rd(2'd2, v); check8("R4 level 1 when FIFO off", v, 8'h04);
    rd(2'd0, v); check8("R12 oldest char", v, 8'hA1);
    rd(2'd2, v); check8("R9 transmit-empty reported", v, 8'h02);
    rd(2'd2, v); check8("R9 cleared by ident read", v, 8'h01);
    check8("R10 irq falls", {7'd0, irq}, 8'h00);
    rd(2'd0, v); check8("R8 second char dropped", v, 8'h00);

    // FIFO on, threshold 4 then 14
    wr(2'd2, 8'h41);
    for (int i = 0; i < 3; i++) push(8'hB0 + 8'(i));
    rd(2'd2, v); check8("R6 none pending, FIFO on", v, 8'hC1);
    push(8'hB3);
    rd(2'd2, v); check8("R4 threshold 4 reached", v, 8'hC4);
    rd(2'd0, v); check8("R12 first in FIFO", v, 8'hB0);
    rd(2'd2, v); check8("R4 below threshold 4", v, 8'hC1);
    wr(2'd2, 8'hC1);
    for (int i = 0; i < 10; i++) push(8'hC0 + 8'(i));
    rd(2'd2, v); check8("R4 13 below threshold 14", v, 8'hC1);
    push(8'hCA);
    rd(2'd2, v); check8("R4 threshold 14 reached", v, 8'hC4);
    push(8'hCB); push(8'hCC); push(8'hCD);
    rd(2'd2, v); check8("R8 overrun at 16", v, 8'hC6);
    rd(2'd3, v); check8("R8 line status overrun", v, 8'h23);
    rd(2'd0, v); check8("R12 order kept", v, 8'hB1);

    // R3 flush and self-clearing
    wr(2'd2, 8'hC3);
    rd(2'd3, v); check8("R3 receive flushed", v, 8'h20);
    push(8'hD0);
    wr(2'd2, 8'hC1);
    rd(2'd3, v); check8("R3 no flush without bit 1", v, 8'h21);
    rd(2'd0, v); check8("R3 char kept", v, 8'hD0);

    // transmit path
    tx_ready = 1'b0;
    wr(2'd0, 8'h11); wr(2'd0, 8'h22); wr(2'd0, 8'h33);
    check8("R11 tx_valid", {7'd0, tx_valid}, 8'h01);
    check8("R11 head char", tx_char, 8'h11);
    rd(2'd2, v); check8("R9 cleared by write", v, 8'hC1);
    for (int i = 0; i < 13; i++) wr(2'd0, 8'h40 + 8'(i));
    wr(2'd0, 8'h99);
    tx_ready = 1'b1;
    pops = 0;
    for (int n = 0; n < 40 && tx_valid; n++) begin
      pops++;
      tick();
    end
    check8("R11 full write dropped, 16 sent", 8'(pops), 8'd16);
    tick(); check8("R9 irq after drain", {7'd0, irq}, 8'h01);
    rd(2'd2, v); check8("R9 transmit-empty after drain", v, 8'hC2);
    tick(); check8("R10 irq clears", {7'd0, irq}, 8'h00);

    // R5 masking
    wr(2'd2, 8'h01);
    push(8'hE0);
    tick(); check8("R4 level 1 in FIFO mode", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00);
    tick(); check8("R5 masked irq", {7'd0, irq}, 8'h00);
    rd(2'd2, v); check8("R5 masked ident", v, 8'hC1);

    // threshold 8
    wr(2'd2, 8'h83);
    wr(2'd1, 8'h01);
    for (int i = 0; i < 7; i++) push(8'h70 + 8'(i));
    tick(); tick(); check8("R4 seven below 8", {7'd0, irq}, 8'h00);
    push(8'h77);
    tick(); check8("R4 eight reaches 8", {7'd0, irq}, 8'h01);

    // R3 transmit flush, R2 mode change
    tx_ready = 1'b0;
    wr(2'd0, 8'h77);
    wr(2'd2, 8'h85);
    check8("R3 transmit flushed", {7'd0, tx_valid}, 8'h00);
    rd(2'd3, v); check8("R3 receive kept by bit 2", v, 8'h21);
    wr(2'd2, 8'h00);
    rd(2'd3, v); check8("R2 mode change flushes", v, 8'h20);
    rd(2'd2, v); check8("R6 bits 7:6 clear when off", v, 8'h01);
    wr(2'd0, 8'h55); wr(2'd0, 8'h66);
    check8("R2 single holding char", tx_char, 8'h55);
    tx_ready = 1'b1;
    pops = 0;
    for (int n = 0; n < 10 && tx_valid; n++) begin
      pops++;
      tick();
    end
    check8("R2 one char sent when off", 8'(pops), 8'd1);

    tick();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule